// File: doc/BRIEF.md
# Two-Road Intersection Signal Controller

This block runs the lights at a crossing of a busy main highway and a quiet farm road. The highway shows green by default. The farm road gets a turn only when its car sensor reports waiting traffic. The design has two parts. A four-state sequencer picks the lamp colour for each road. A separate restartable interval timer counts clock cycles and raises a short flag and a long flag.

The sequencer changes state only when the sensor input and a timer flag allow it. On the cycle it takes a transition, it pulses a restart to the timer. Because of this split, the sequencer logic has no tie to the clock period. The light durations are set only by the SHORT_CYCLES and LONG_CYCLES parameters, both counted in clock cycles. LONG_CYCLES must be greater than SHORT_CYCLES.

Top module: `tlc_top`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, the sequencer is in highway-green with the timer count at 0 and both flags low. The outputs read hwy_lamp_o = 10, farm_lamp_o = 00 and tmr_restart_o = 0 while car_i is 0.
- R2: Lamp codes are 00 = red, 01 = yellow and 10 = green, and code 11 never appears. Whenever the highway is not red, the farm road is red, and whenever the farm road is not red, the highway is red.
- R3: In highway-green, the block moves to highway-yellow only on a cycle where car_i = 1 and the long flag is set. In any other cycle it stays in highway-green.
- R4: In highway-yellow, the block moves to farm-green on the first cycle the short flag is set. In farm-yellow, it moves to highway-green on the same rule.
- R5: In farm-green, the block moves to farm-yellow on any cycle where car_i = 0 or the long flag is set. Otherwise it stays in farm-green.
- R6: tmr_restart_o is a Mealy output. It is 1 in exactly the cycles in which the current state and car_i select a transition, and 0 in every cycle where the state holds.
- R7: After a restart, the timer counts cycles from 0. The short flag is set once the count reaches SHORT_CYCLES, and the long flag once the count reaches LONG_CYCLES. The count then saturates and both flags stay set until the next restart. As a result, highway green lasts at least LONG_CYCLES+1 cycles.
- R8: The lamp outputs are registered. They change on the same clock edge that takes a transition, and they do not change at any other edge.
- R9: The car sensor has no effect during either yellow state. Each yellow lasts exactly SHORT_CYCLES+1 cycles, whatever car_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| car_i | input | 1 | Farm-road car sensor, 1 = cars waiting |
| hwy_lamp_o | output | 2 | Highway lamp code (00 red, 01 yellow, 10 green) |
| farm_lamp_o | output | 2 | Farm-road lamp code (00 red, 01 yellow, 10 green) |
| tmr_restart_o | output | 1 | Timer restart strobe, high in the cycle a transition is taken |

## Verification
A wrong sequencer state shows up at the lamp outputs on the very next clock edge, because the lamps are registered straight from the next state. The scoreboard's cycle-accurate model catches it in that same cycle. A timer count that is off by even one cycle is harder to see. It stays hidden until a flag is consulted, and then it appears as a yellow or green phase that is one cycle too long or too short. For that reason, the bench measures the length of every yellow and highway-green run in addition to comparing cycle by cycle. A wrong restart strobe appears at once on tmr_restart_o. It also surfaces later as a phase of the wrong length.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    LAMP_RED = 2'b00,
    LAMP_YEL = 2'b01,
    LAMP_GRN = 2'b10
  } lamp_e;

  typedef enum logic [1:0] {
    ST_HWY_GO,
    ST_HWY_WARN,
    ST_FARM_GO,
    ST_FARM_WARN
  } seq_state_e;

  // road 0 = highway, road 1 = farm
  function automatic lamp_e lamp_of(seq_state_e st, int road);
    lamp_e l;
    l = LAMP_RED;
    unique case (st)
      ST_HWY_GO:    if (road == 0) l = LAMP_GRN;
      ST_HWY_WARN:  if (road == 0) l = LAMP_YEL;
      ST_FARM_GO:   if (road == 1) l = LAMP_GRN;
      ST_FARM_WARN: if (road == 1) l = LAMP_YEL;
      default:      l = LAMP_RED;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/tlc_timer.sv
module tlc_timer #(
  parameter int SHORT_CYCLES = 5,
  parameter int LONG_CYCLES  = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic short_o,
  output logic long_o
);
  localparam int CNT_W = $clog2(LONG_CYCLES + 1);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_CYCLES);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (restart_i)    cnt_q <= '0;
    else if (cnt_q != LONG_C) cnt_q <= cnt_q + 1'b1;  // saturate at long
  end

  assign short_o = (cnt_q >= SHORT_C);
  assign long_o  = (cnt_q == LONG_C);

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
  import tlc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       car_i,
  input  logic       short_i,
  input  logic       long_i,
  output seq_state_e nxt_o,
  output logic       restart_o
);
  seq_state_e st_q, nxt;

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      ST_HWY_GO:    if (car_i && long_i)  nxt = ST_HWY_WARN;
      ST_HWY_WARN:  if (short_i)          nxt = ST_FARM_GO;
      ST_FARM_GO:   if (!car_i || long_i) nxt = ST_FARM_WARN;
      ST_FARM_WARN: if (short_i)          nxt = ST_HWY_GO;
      default:                            nxt = ST_HWY_GO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_HWY_GO;
    else         st_q <= nxt;
  end

  assign nxt_o     = nxt;
  assign restart_o = (nxt != st_q);

endmodule

// File: rtl/tlc_lamps.sv
module tlc_lamps
  import tlc_pkg::*;
#(
  parameter int N_ROADS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  seq_state_e              nxt_i,
  output logic [N_ROADS-1:0][1:0] lamp_o
);
  for (genvar g = 0; g < N_ROADS; g++) begin : g_road
    localparam lamp_e RST_LAMP = (g == 0) ? LAMP_GRN : LAMP_RED;
    logic [1:0] lamp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lamp_q <= RST_LAMP;
      else         lamp_q <= lamp_of(nxt_i, g);
    end
    assign lamp_o[g] = lamp_q;
  end

endmodule

// File: rtl/tlc_top.sv
module tlc_top #(
  parameter int SHORT_CYCLES = 5,
  parameter int LONG_CYCLES  = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       car_i,
  output logic [1:0] hwy_lamp_o,
  output logic [1:0] farm_lamp_o,
  output logic       tmr_restart_o
);
  import tlc_pkg::*;

  localparam int N_ROADS = 2;

  logic                    short_w, long_w, restart_w;
  seq_state_e              nxt_w;
  logic [N_ROADS-1:0][1:0] lamp_w;

  tlc_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_w),
    .short_o  (short_w),
    .long_o   (long_w)
  );

  tlc_sequencer u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .car_i    (car_i),
    .short_i  (short_w),
    .long_i   (long_w),
    .nxt_o    (nxt_w),
    .restart_o(restart_w)
  );

  tlc_lamps #(.N_ROADS(N_ROADS)) u_lamps (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nxt_i (nxt_w),
    .lamp_o(lamp_w)
  );

  assign hwy_lamp_o    = lamp_w[0];
  assign farm_lamp_o   = lamp_w[1];
  assign tmr_restart_o = restart_w;

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       car_i,
  input logic [1:0] hwy_i,
  input logic [1:0] farm_i,
  input logic       restart_i,
  input logic       short_i,
  input logic       long_i
);
  localparam logic [1:0] RED = 2'b00, YEL = 2'b01, GRN = 2'b10;

  a_r2_one_red: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwy_i == RED) || (farm_i == RED));

  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwy_i != 2'b11) && (farm_i != 2'b11));

  a_r3_hold_green: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwy_i == GRN && !(car_i && long_i)) |=> (hwy_i == GRN));

  a_r4_yellow_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hwy_i == YEL || farm_i == YEL) && short_i) |-> restart_i);

  a_r5_farm_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (farm_i == GRN && !car_i) |-> restart_i);

  a_r8_change_on_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !$stable({hwy_i, farm_i}));

  a_r8_hold_without_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> $stable({hwy_i, farm_i}));

  a_r7_long_implies_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_i |-> short_i);

  a_r7_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_i && !restart_i) |=> long_i);

  a_r7_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !long_i);

endmodule

bind tlc_top tlc_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .car_i    (car_i),
  .hwy_i    (hwy_lamp_o),
  .farm_i   (farm_lamp_o),
  .restart_i(tmr_restart_o),
  .short_i  (short_w),
  .long_i   (long_w)
);

// File: tb/sim_tlc_top.sv
`timescale 1ns/1ps
module sim_tlc_top;
  localparam int S = 3;
  localparam int L = 8;
  localparam logic [1:0] RED = 2'b00, YEL = 2'b01, GRN = 2'b10;

  logic clk = 1'b0, rst_ni = 1'b0, car = 1'b0;
  logic [1:0] hwy, farm;
  logic rs;

  always #2 clk = ~clk;

  tlc_top #(.SHORT_CYCLES(S), .LONG_CYCLES(L)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .car_i(car),
    .hwy_lamp_o(hwy), .farm_lamp_o(farm), .tmr_restart_o(rs)
  );

  typedef struct {
    logic [1:0] hw;
    logic [1:0] fm;
    logic       rs;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model: 0 HG, 1 HY, 2 FG, 3 FY
  int m_st = 0, m_cnt = 0;

  task automatic step(input logic c);
    exp_t e;
    int nx;
    bit sh, lg;
    car = c;
    sh = (m_cnt >= S);
    lg = (m_cnt >= L);
    nx = m_st;
    case (m_st)
      0: if (c && lg) nx = 1;
      1: if (sh) nx = 2;
      2: if (!c || lg) nx = 3;
      default: if (sh) nx = 0;
    endcase
    e.hw = (m_st == 0) ? GRN : (m_st == 1) ? YEL : RED;
    e.fm = (m_st == 2) ? GRN : (m_st == 3) ? YEL : RED;
    e.rs = (nx != m_st);
    case (m_st)
      0: e.tag = "R3";
      1: e.tag = "R4";
      2: e.tag = "R5";
      default: e.tag = "R9";
    endcase
    q.push_back(e);
    m_cnt = e.rs ? 0 : ((m_cnt < L) ? m_cnt + 1 : m_cnt);
    m_st = nx;
  endtask

  task automatic drive(input logic c, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      step(c);
    end
  endtask

  // monitor: compare against scoreboard, track run lengths
  int hg_run = 0, hy_run = 0, fy_run = 0;
  always @(negedge clk) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;  // lamps registered, change on the transition edge (R8)
      if (hwy !== e.hw || farm !== e.fm) begin
        n_bad++;
        $display("FAIL %s/R8 lamps: actual hwy=%b farm=%b expected hwy=%b farm=%b",
                 e.tag, hwy, farm, e.hw, e.fm);
      end
      n_chk++;
      if (rs !== e.rs) begin
        n_bad++;
        $display("FAIL R6 restart in %s state: actual %b expected %b", e.tag, rs, e.rs);
      end
      n_chk++;
      if (hwy != RED && farm != RED) begin
        n_bad++;
        $display("FAIL R2 both non-red: actual hwy=%b farm=%b expected one 00", hwy, farm);
      end
      // run lengths
      if (hwy == GRN) hg_run++;
      else if (hg_run > 0) begin
        n_chk++;
        if (hg_run < L + 1) begin
          n_bad++;
          $display("FAIL R7 highway green cut short: actual %0d expected >= %0d", hg_run, L + 1);
        end
        hg_run = 0;
      end
      if (hwy == YEL) hy_run++;
      else if (hy_run > 0) begin
        n_chk++;
        if (hy_run != S + 1) begin
          n_bad++;
          $display("FAIL R9 highway yellow length: actual %0d expected %0d", hy_run, S + 1);
        end
        hy_run = 0;
      end
      if (farm == YEL) fy_run++;
      else if (fy_run > 0) begin
        n_chk++;
        if (fy_run != S + 1) begin
          n_bad++;
          $display("FAIL R9 farm yellow length: actual %0d expected %0d", fy_run, S + 1);
        end
        fy_run = 0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #80000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] lf;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (hwy !== GRN || farm !== RED || rs !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: actual hwy=%b farm=%b rs=%b expected 10 00 0",
               hwy, farm, rs);
    end
    @(posedge clk); #1;
    rst_ni = 1'b1;
    step(1'b0);
    // R3: no cars, highway keeps green long after long flag
    drive(1'b0, 3 * L);
    // R3/R7: cars held, green ends only after long; full cycle with farm long limit (R5)
    drive(1'b1, 4 * L);
    // R5: farm released early when sensor drops
    drive(1'b0, 2 * L);
    drive(1'b1, L + 2);
    drive(1'b0, 2);
    drive(1'b0, 2 * L);
    // R9: sensor toggles during yellow
    for (int k = 0; k < 6 * L; k++) begin
      @(posedge clk); #1;
      step(k[0]);
    end
    // pseudo-random traffic
    lf = 8'hA5;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      step(lf[0] | lf[3]);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    // R1: reset mid-run returns to highway green
    @(posedge clk); #1;
    rst_ni = 1'b0;
    car = 1'b1;
    #1;
    n_chk++;
    if (hwy !== GRN || farm !== RED) begin
      n_bad++;
      $display("FAIL R1 async reset: actual hwy=%b farm=%b expected 10 00", hwy, farm);
    end
    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end

endmodule